// File: doc/BRIEF.md
# External Interrupt Request Controller

This block conditions an active-low external interrupt pin and turns it into a request for the interrupt sequencer. It brings the pin into the clock domain and detects its falling edge. A request flag holds the request until it is cleared. A one-byte control/status register on a simple 8-bit register bus lets software choose the trigger mode, mask the request locally and drop a pending request.

The trigger mode is either edge-only, or edge plus low level. Software can set it only with the first register write after reset. A local enable masks the pending output without touching the CPU-wide mask. The request clears in one of two ways: software writes the acknowledge bit, or the sequencer pulses its service-entry strobe. A new edge that arrives while the service routine runs is therefore kept.

Register layout (reads are combinational):

| Bit | Meaning |
|-----|---------|
| 0 | enable (read/write) |
| 1 | mode: 0 = edge-only, 1 = edge plus low level |
| 2 | acknowledge (write 1 to clear) |
| 3 | request flag (read-only) |
| 7:4 | read as 0 |

Top module: `extirq_ctrl`

## Requirements
- R1: The pin passes through two synchronising flops, and a falling edge is the synchronised value going from 1 to 0. After the pin falls, the request flag (bit 3) reads 1 following the third rising clock edge.
- R2: In edge-only mode (bit 1 = 0), a pin held low does not set the flag again after the flag has been cleared.
- R3: In level mode (bit 1 = 1), the flag is set on every cycle in which the synchronised pin is low. A set in the same cycle as a clear wins.
- R4: Only the first register write after reset takes bit 1 (mode). The mode bit of every later write is ignored.
- R5: irq_pending equals the request flag ANDed with the enable bit (bit 0).
- R6: Bit 3 shows the request flag, and writes to bit 3 have no effect on it.
- R7: Writing 1 to bit 2 clears the flag unless a set happens in the same cycle. Bit 2 always reads 0, and bits 7:4 read 0.
- R8: A svc_ack pulse clears the flag. A falling edge detected in the same cycle as the pulse still leaves the flag at 1.
- R9: After reset, the enable bit, the mode bit and the flag are 0, and irq_pending is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| svc_ack | input | 1 | Service-entry strobe from the interrupt sequencer |
| irq_pending | output | 1 | Masked request to the interrupt sequencer |

## Verification
A register write takes effect at the next rising edge. Its result is due one cycle after it is applied, and so is a svc_ack pulse. A pin change passes through the synchroniser and the flag, and reaches the flag three edges later. Every stimulus in the bench is driven on a falling clock edge, and the bench advances exactly one rising edge before it samples on the next falling edge. The pin latency therefore appears as two rows of expected zero before the flag rises, and the set-wins cases line svc_ack or the acknowledge write up with the cycle in which the edge is detected.

// File: rtl/extirq_ctrl.sv
module extirq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_pin_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       svc_ack,
  output logic       irq_pending
);

  logic sync1, sync2, sync_prev;
  logic en, mode, locked, flag;
  logic fall, set_req, clr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= 1'b1;
      sync2     <= 1'b1;
      sync_prev <= 1'b1;
    end else begin
      sync1     <= irq_pin_n;
      sync2     <= sync1;
      sync_prev <= sync2;
    end
  end

  assign fall    = sync_prev & ~sync2;
  assign set_req = fall | (mode & ~sync2);
  assign clr_req = svc_ack | (reg_wr & reg_wdata[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      mode   <= 1'b0;
      locked <= 1'b0;
    end else if (reg_wr) begin
      en     <= reg_wdata[0];
      locked <= 1'b1;
      if (!locked) mode <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_req) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  assign reg_rdata   = {4'b0000, flag, 1'b0, mode, en};
  assign irq_pending = flag & en;

endmodule

module extirq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       svc_ack,
  input logic       irq_pending,
  input logic [7:0] reg_rdata,
  input logic       flag,
  input logic       mode,
  input logic       locked,
  input logic       set_req
);

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (reg_rdata[0] && reg_rdata[3]));                         // R5
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && locked) |=> $stable(mode));                                   // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> flag);                                                       // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[2] && !set_req) |=> !flag);                         // R7
  AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack && !set_req) |=> !flag);                                        // R8
  AST_FLAG_ONLY_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_req));                                         // R6
  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[2] == 1'b0));                                      // R7

endmodule

bind extirq_ctrl extirq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .svc_ack(svc_ack), .irq_pending(irq_pending), .reg_rdata(reg_rdata),
  .flag(flag), .mode(mode), .locked(locked), .set_req(set_req)
);

// File: tb/extirq_ctrl_tb.sv
module extirq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_pin_n = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       svc_ack = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq_pending;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  extirq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .svc_ack(svc_ack),
    .irq_pending(irq_pending)
  );

  // row: {req[3:0], pin, wr, wdata[7:0], svc, exp_rdata[7:0], exp_pend}
  localparam int NROWS = 17;
  localparam logic [23:0] VEC [NROWS] = '{
    {4'd4, 1'b1, 1'b1, 8'h01, 1'b0, 8'h01, 1'b0}, // R4 first write, edge-only, enable
    {4'd1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h01, 1'b0}, // R1 pin falls
    {4'd1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h01, 1'b0}, // R1
    {4'd1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h09, 1'b1}, // R1 flag on third edge
    {4'd7, 1'b0, 1'b1, 8'h05, 1'b0, 8'h01, 1'b0}, // R7 acknowledge clears
    {4'd2, 1'b0, 1'b0, 8'h00, 1'b0, 8'h01, 1'b0}, // R2 held low, no re-set
    {4'd2, 1'b1, 1'b0, 8'h00, 1'b0, 8'h01, 1'b0}, // R2
    {4'd2, 1'b0, 1'b0, 8'h00, 1'b0, 8'h01, 1'b0}, // R2 new fall
    {4'd8, 1'b0, 1'b0, 8'h00, 1'b1, 8'h01, 1'b0}, // R8 svc with nothing pending
    {4'd8, 1'b0, 1'b0, 8'h00, 1'b1, 8'h09, 1'b1}, // R8 edge beats svc
    {4'd8, 1'b1, 1'b0, 8'h00, 1'b1, 8'h01, 1'b0}, // R8 svc clears
    {4'd4, 1'b1, 1'b1, 8'h02, 1'b0, 8'h00, 1'b0}, // R4 mode write ignored
    {4'd5, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0}, // R5
    {4'd5, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0}, // R5
    {4'd5, 1'b0, 1'b0, 8'h00, 1'b0, 8'h08, 1'b0}, // R5 flag set but masked
    {4'd6, 1'b1, 1'b1, 8'h01, 1'b0, 8'h09, 1'b1}, // R6 writing bit3 as 0 keeps flag
    {4'd7, 1'b1, 1'b1, 8'h0C, 1'b0, 8'h00, 1'b0}  // R7 ack clears, bit3 write ignored
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input logic pin, input logic wr, input logic [7:0] wd, input logic svc);
    irq_pin_n = pin; reg_wr = wr; reg_wdata = wd; svc_ack = svc;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; svc_ack = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_pin_n = 1'b1; reg_wr = 1'b0; svc_ack = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk("R9 reset rdata", reg_rdata, 8'h00);
    chk("R9 reset pending", {7'd0, irq_pending}, 8'h00);

    for (int i = 0; i < NROWS; i++) begin
      step(VEC[i][19], VEC[i][18], VEC[i][17:10], VEC[i][9]);
      chk($sformatf("R%0d row %0d rdata", VEC[i][23:20], i), reg_rdata, VEC[i][8:1]);
      chk($sformatf("R%0d row %0d pending", VEC[i][23:20], i), {7'd0, irq_pending}, {7'd0, VEC[i][0]});
    end

    // Level mode, fresh reset
    do_reset();
    chk("R9 second reset", reg_rdata, 8'h00);
    step(1'b1, 1'b1, 8'h03, 1'b0);
    chk("R4 level mode taken", reg_rdata, 8'h03);
    step(1'b0, 1'b0, 8'h00, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0);
    chk("R1 level not yet", reg_rdata, 8'h03);
    step(1'b0, 1'b0, 8'h00, 1'b0);
    chk("R3 level set", reg_rdata, 8'h0B);
    step(1'b0, 1'b1, 8'h07, 1'b0);
    chk("R3 set wins over ack", reg_rdata, 8'h0B);
    step(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R3 set wins over svc", reg_rdata, 8'h0B);
    step(1'b1, 1'b0, 8'h00, 1'b0);
    step(1'b1, 1'b0, 8'h00, 1'b0);
    step(1'b1, 1'b0, 8'h00, 1'b0);
    chk("R3 flag held after pin high", {7'd0, irq_pending}, 8'h01);
    step(1'b1, 1'b1, 8'h05, 1'b0);
    chk("R4 mode kept, R7 ack clears", reg_rdata, 8'h03);
    chk("R5 pending drops", {7'd0, irq_pending}, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule